// File: doc/BRIEF.md
# Register File Self-Test Engine (Logarithmic Index Patterns)

This engine tests a multi-ported register file through its ordinary write and read ports, one word per cycle. Every storage cell gets a unique number, its global index, equal to register number times word width plus bit position. For each bit position k of that index, the engine runs two phases. In the first phase every cell is written with bit k of its own index. In the second phase every cell is written with the complement of that bit. Because any two cells have different indices, they hold opposite values in at least one phase, in both orders. This exposes stuck-at-0 and stuck-at-1 cells and shorts between any pair of bit lines. The number of phases grows with the base-2 logarithm of the cell count, not with the cell count itself.

Read-back words are not compared inside the engine. They are folded into a multiple-input signature register (MISR), and the final signature is compared externally against a value computed ahead of time. Write cycles in which a register would receive the same word it already holds from the previous phase are skipped, so the write port stays idle in those cycles. After a run, `done` stays high and the signature stays frozen until the next start.

Top module: `rfbist_engine`

## Requirements
- R1: While reset is asserted and after reset, `busy`, `done`, `wr_en` and `rd_en` are 0, and `signature` equals MISR_SEED (default all ones).
- R2: A `start` pulse sampled while the engine is idle or done launches a run. A `start` sampled while `busy` is high has no effect: the run length and the final signature are unchanged.
- R3: There are 2*IDXW phases, where IDXW = clog2(NREG*WIDTH); the defaults give 12, so 24 phases. In phase p, let k = p/2 and pol = p mod 2. Bit b of the word written to register r equals bit k of (r*WIDTH+b), XOR pol.
- R4: Each phase first sweeps the writes over registers 0 to NREG-1 in ascending order, one register per cycle. It then sweeps the reads over registers 0 to NREG-1 in ascending order, one per cycle. `wr_en` and `rd_en` are never high in the same cycle. Every run issues exactly 2*IDXW*NREG reads.
- R5: In phase 0 every register is written. In phase p>0, the write to register r is suppressed (`wr_en` low in its slot) exactly when its phase-p word equals its phase-(p-1) word.
- R6: The signature is reloaded with MISR_SEED when a run is launched. Each read word is folded RD_LAT cycles after its read cycle as sig = (sig<<1) XOR (sig[WIDTH-1] ? MISR_POLY : 0) XOR data. The default MISR_POLY is 64'h1B.
- R7: `done` rises exactly 2*IDXW*(2*NREG+RD_LAT) clock edges after the edge that samples the launching `start` (3048 with the defaults). `busy` is high in between and is never high together with `done`.
- R8: Once `done` is high it stays high, with `signature` stable, until the next launch.
- R9: A register file with a stuck cell, or with two bit lines shorted as a wired AND, produces a signature that differs from the fault-free one.
- R10: Whenever `wr_en` or `rd_en` is high, the address is below NREG.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | AW (6) | Register file write address |
| wr_data | output | WIDTH (64) | Register file write data |
| rd_en | output | 1 | Register file read strobe |
| rd_addr | output | AW (6) | Register file read address |
| rd_data | input | WIDTH (64) | Read data, valid RD_LAT cycles after `rd_en` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, signature final |
| signature | output | WIDTH (64) | MISR value |

## Verification
Write strobes and addresses are combinational from the sequencer state. The bench's register file model checks them on the falling edge of the same cycle, and it latches read data at the rising edge, so the data is valid one cycle later, matching RD_LAT=1. `done` is due exactly 3048 edges after the edge that samples `start`. The bench counts falling edges from that edge and compares the count at the first falling edge where `done` is high. The signature is final in the same cycle that `done` first shows, because the last fold happens on the edge that enters the done state. The bench compares it there and again after 20 further cycles.

// File: rtl/rfbist_pkg.sv
package rfbist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_READ  = 3'd2,
      ST_DRAIN = 3'd3,
      ST_DONE  = 3'd4
   } bist_state_e;
endpackage

// File: rtl/rfbist_patgen.sv
module rfbist_patgen #(
   parameter int NREG  = 63,
   parameter int WIDTH = 64,
   parameter int IDXW  = 12,
   parameter int AW    = 6,
   parameter int PW    = 5
) (
   input  logic [AW-1:0]    reg_idx,
   input  logic [PW-1:0]    phase,
   output logic [WIDTH-1:0] word,
   output logic             dup
);
   logic [PW-1:0]    prev_phase;
   logic [WIDTH-1:0] prev_word;

   assign prev_phase = phase - 1'b1;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [IDXW-1:0] cell_idx;
      assign cell_idx  = IDXW'(reg_idx) * IDXW'(WIDTH) + IDXW'(b);
      assign word[b]      = cell_idx[phase[PW-1:1]] ^ phase[0];
      assign prev_word[b] = cell_idx[prev_phase[PW-1:1]] ^ prev_phase[0];
   end

   assign dup = (phase != '0) && (word == prev_word);
endmodule

// File: rtl/rfbist_seq.sv
module rfbist_seq
   import rfbist_pkg::*;
#(
   parameter int NREG   = 63,
   parameter int NPHASE = 24,
   parameter int RD_LAT = 1,
   parameter int AW     = 6,
   parameter int PW     = 5,
   parameter int DCW    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          dup,
   output logic [AW-1:0] reg_idx,
   output logic [PW-1:0] phase,
   output logic          wr_en,
   output logic          rd_en,
   output logic          busy,
   output logic          done,
   output logic          launch
);
   localparam logic [AW-1:0]  LAST_REG   = AW'(NREG - 1);
   localparam logic [PW-1:0]  LAST_PHASE = PW'(NPHASE - 1);
   localparam logic [DCW-1:0] DRAIN_LD   = DCW'(RD_LAT - 1);

   bist_state_e    state;
   logic [DCW-1:0] drain_cnt;

   assign launch = start && (state == ST_IDLE || state == ST_DONE);
   assign wr_en  = (state == ST_WRITE) && !dup;
   assign rd_en  = (state == ST_READ);
   assign busy   = (state == ST_WRITE) || (state == ST_READ) || (state == ST_DRAIN);
   assign done   = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         reg_idx   <= '0;
         phase     <= '0;
         drain_cnt <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (launch) begin
                  state   <= ST_WRITE;
                  reg_idx <= '0;
                  phase   <= '0;
               end
            end
            ST_WRITE: begin
               if (reg_idx == LAST_REG) begin
                  state   <= ST_READ;
                  reg_idx <= '0;
               end else begin
                  reg_idx <= reg_idx + 1'b1;
               end
            end
            ST_READ: begin
               if (reg_idx == LAST_REG) begin
                  state     <= ST_DRAIN;
                  reg_idx   <= '0;
                  drain_cnt <= DRAIN_LD;
               end else begin
                  reg_idx <= reg_idx + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (drain_cnt == '0) begin
                  if (phase == LAST_PHASE) begin
                     state <= ST_DONE;
                  end else begin
                     phase <= phase + 1'b1;
                     state <= ST_WRITE;
                  end
               end else begin
                  drain_cnt <= drain_cnt - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rfbist_misr.sv
module rfbist_misr #(
   parameter int             WIDTH  = 64,
   parameter int             RD_LAT = 1,
   parameter logic [WIDTH-1:0] POLY = 64'h1B,
   parameter logic [WIDTH-1:0] SEED = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             rd_issue,
   input  logic [WIDTH-1:0] rd_data,
   output logic [WIDTH-1:0] sig
);
   logic fold;

   if (RD_LAT == 1) begin : g_lat1
      logic vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q <= 1'b0;
         else        vld_q <= rd_issue;
      end
      assign fold = vld_q;
   end else begin : g_latn
      logic [RD_LAT-1:0] vld_sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_sr <= '0;
         else        vld_sr <= {vld_sr[RD_LAT-2:0], rd_issue};
      end
      assign fold = vld_sr[RD_LAT-1];
   end

   logic [WIDTH-1:0] sig_next;
   assign sig_next = {sig[WIDTH-2:0], 1'b0} ^ (sig[WIDTH-1] ? POLY : '0) ^ rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sig <= SEED;
      else if (clear) sig <= SEED;
      else if (fold)  sig <= sig_next;
   end
endmodule

// File: rtl/rfbist_engine.sv
module rfbist_engine #(
   parameter int               NREG      = 63,
   parameter int               WIDTH     = 64,
   parameter int               RD_LAT    = 1,
   parameter logic [WIDTH-1:0] MISR_POLY = 64'h1B,
   parameter logic [WIDTH-1:0] MISR_SEED = '1,
   localparam int              AW        = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [WIDTH-1:0] wr_data,
   output logic             rd_en,
   output logic [AW-1:0]    rd_addr,
   input  logic [WIDTH-1:0] rd_data,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] signature
);
   localparam int IDXW   = $clog2(NREG * WIDTH);
   localparam int NPHASE = 2 * IDXW;
   localparam int PW     = $clog2(NPHASE);
   localparam int DCW    = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);

   initial begin
      assert (NREG >= 2)   else $error("NREG must be at least 2");
      assert (WIDTH >= 2)  else $error("WIDTH must be at least 2");
      assert (RD_LAT >= 1) else $error("RD_LAT must be at least 1");
   end

   logic [AW-1:0] reg_idx;
   logic [PW-1:0] phase;
   logic          dup;
   logic          launch;

   rfbist_patgen #(
      .NREG(NREG), .WIDTH(WIDTH), .IDXW(IDXW), .AW(AW), .PW(PW)
   ) u_pat (
      .reg_idx(reg_idx), .phase(phase), .word(wr_data), .dup(dup)
   );

   rfbist_seq #(
      .NREG(NREG), .NPHASE(NPHASE), .RD_LAT(RD_LAT), .AW(AW), .PW(PW), .DCW(DCW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dup(dup),
      .reg_idx(reg_idx), .phase(phase), .wr_en(wr_en), .rd_en(rd_en),
      .busy(busy), .done(done), .launch(launch)
   );

   rfbist_misr #(
      .WIDTH(WIDTH), .RD_LAT(RD_LAT), .POLY(MISR_POLY), .SEED(MISR_SEED)
   ) u_misr (
      .clk(clk), .rst_n(rst_n), .clear(launch), .rd_issue(rd_en),
      .rd_data(rd_data), .sig(signature)
   );

   assign wr_addr = reg_idx;
   assign rd_addr = reg_idx;
endmodule

// File: rtl/rfbist_checker.sv
module rfbist_checker #(
   parameter int NREG  = 63,
   parameter int WIDTH = 64,
   parameter int AW    = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             wr_en,
   input logic [AW-1:0]    wr_addr,
   input logic             rd_en,
   input logic [AW-1:0]    rd_addr,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] signature
);
   AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en)); // R4
   AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr > $past(wr_addr))); // R4
   AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1))); // R4
   AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr < AW'(NREG))); // R10
   AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr < AW'(NREG))); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_en && !rd_en)); // R1
   AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R2
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(signature))); // R8
   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy)); // R7
endmodule

bind rfbist_engine rfbist_checker #(.NREG(NREG), .WIDTH(WIDTH), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
   .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .done(done), .signature(signature)
);

// File: tb/tb_rfbist_engine.sv
`timescale 1ns/1ps
module tb_rfbist_engine;
   localparam int NREG    = 63;
   localparam int W       = 64;
   localparam int RDL     = 1;
   localparam int IDXW    = $clog2(NREG * W);
   localparam int NPH     = 2 * IDXW;
   localparam int EXP_CYC = NPH * (2 * NREG + RDL);
   localparam logic [W-1:0] POLY = 64'h1B;
   localparam logic [W-1:0] SEED = '1;

   // fault table: {kind(2: 0 none,1 stuck,2 bridge), val, reg(6), b1(6), b2(6)}
   localparam int NTAB = 7;
   localparam logic [20:0] FTAB [NTAB] = '{
      {2'd0, 1'b0, 6'd0,  6'd0,  6'd0},
      {2'd1, 1'b0, 6'd0,  6'd0,  6'd0},
      {2'd1, 1'b1, 6'd62, 6'd63, 6'd0},
      {2'd1, 1'b0, 6'd31, 6'd17, 6'd0},
      {2'd2, 1'b0, 6'd0,  6'd5,  6'd6},
      {2'd2, 1'b0, 6'd0,  6'd0,  6'd63},
      {2'd0, 1'b0, 6'd0,  6'd0,  6'd0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         wr_en, rd_en, busy, done;
   logic [5:0]   wr_addr, rd_addr;
   logic [W-1:0] wr_data, rd_data, signature;

   always #5 clk = ~clk;

   rfbist_engine #(.NREG(NREG), .WIDTH(W), .RD_LAT(RDL), .MISR_POLY(POLY), .MISR_SEED(SEED)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .done(done), .signature(signature)
   );

   // register file model with fault injection
   logic [W-1:0] mem [NREG];
   logic [1:0]   f_kind = 2'd0;
   logic         f_val = 1'b0;
   int           f_r = 0, f_b1 = 0, f_b2 = 0;
   logic [W-1:0] rd_q = '0;
   assign rd_data = rd_q;

   initial for (int i = 0; i < NREG; i++) mem[i] = '0;

   always @(posedge clk) begin
      logic [W-1:0] d;
      logic         a;
      if (wr_en) begin
         d = wr_data;
         if (f_kind == 2'd1 && int'(wr_addr) == f_r) d[f_b1] = f_val;
         mem[wr_addr] <= d;
      end
      if (rd_en) begin
         d = mem[rd_addr];
         if (f_kind == 2'd2) begin
            a = d[f_b1] & d[f_b2];
            d[f_b1] = a;
            d[f_b2] = a;
         end
         rd_q <= d;
      end
   end

   function automatic logic [W-1:0] exp_word(int r, int ph);
      logic [W-1:0] w;
      for (int b = 0; b < W; b++)
         w[b] = 1'(((r * W + b) >> (ph / 2)) & 1) ^ 1'(ph % 2);
      return w;
   endfunction

   function automatic logic [W-1:0] misr_step(logic [W-1:0] s, logic [W-1:0] d);
      return {s[W-2:0], 1'b0} ^ (s[W-1] ? POLY : '0) ^ d;
   endfunction

   function automatic logic [W-1:0] golden_sig();
      logic [W-1:0] s = SEED;
      for (int p = 0; p < NPH; p++)
         for (int r = 0; r < NREG; r++) s = misr_step(s, exp_word(r, p));
      return s;
   endfunction

   function automatic int exp_writes();
      int n = 0;
      for (int p = 0; p < NPH; p++)
         for (int r = 0; r < NREG; r++)
            if (p == 0 || exp_word(r, p) != exp_word(r, p - 1)) n++;
      return n;
   endfunction

   // port monitor, re-armed at each accepted launch
   int mon_ph = 0, mon_rd_next = 0, mon_wr_last = -1;
   int wr_cnt = 0, rd_cnt = 0, wr_err = 0, rd_err = 0;
   always @(negedge clk) begin
      if (start && !busy) begin
         mon_ph = 0; mon_rd_next = 0; mon_wr_last = -1;
         wr_cnt = 0; rd_cnt = 0; wr_err = 0; rd_err = 0;
      end else if (rst_n) begin
         if (wr_en) begin
            wr_cnt++;
            if (wr_data != exp_word(int'(wr_addr), mon_ph)) wr_err++;
            if (mon_ph > 0 && exp_word(int'(wr_addr), mon_ph) == exp_word(int'(wr_addr), mon_ph - 1)) wr_err++;
            if (int'(wr_addr) <= mon_wr_last || mon_rd_next != 0) wr_err++;
            mon_wr_last = int'(wr_addr);
         end
         if (rd_en) begin
            rd_cnt++;
            if (int'(rd_addr) != mon_rd_next) rd_err++;
            if (int'(rd_addr) == NREG - 1) begin
               mon_rd_next = 0; mon_ph++; mon_wr_last = -1;
            end else begin
               mon_rd_next = int'(rd_addr) + 1;
            end
         end
      end
   end

   int n_run = 0, n_fail = 0;
   logic [W-1:0] gold;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_bist(input int pulse_at, output int cyc);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         start = (cyc == pulse_at);
      end while (!done && cyc < 10000);
      start = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int cyc;
      logic [W-1:0] held;
      gold = golden_sig();

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!busy && !done, "R1", "busy/done in reset", {62'd0, busy, done}, 0);
      check(!wr_en && !rd_en, "R1", "strobes in reset", {62'd0, wr_en, rd_en}, 0);
      check(signature == SEED, "R1", "signature in reset", signature, SEED);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done && !wr_en && !rd_en, "R1", "idle after reset",
            {60'd0, busy, done, wr_en, rd_en}, 0);

      // table of fault cases
      for (int t = 0; t < NTAB; t++) begin
         f_kind = FTAB[t][20:19];
         f_val  = FTAB[t][18];
         f_r    = int'(FTAB[t][17:12]);
         f_b1   = int'(FTAB[t][11:6]);
         f_b2   = int'(FTAB[t][5:0]);
         run_bist(-1, cyc);
         check(cyc == EXP_CYC, "R7", "cycles to done", W'(cyc), W'(EXP_CYC));
         if (f_kind == 2'd0)
            check(signature == gold, "R6", "fault-free signature", signature, gold);
         else
            check(signature != gold, "R9", "faulty signature differs", signature, gold);
         check(wr_err == 0, "R3", "write data/order errors", W'(wr_err), 0);
         check(wr_cnt == exp_writes(), "R5", "write count with skips", W'(wr_cnt), W'(exp_writes()));
         check(rd_cnt == NPH * NREG && rd_err == 0, "R4", "read count/order",
               W'(rd_cnt + 100000 * rd_err), W'(NPH * NREG));
         check(!busy && done, "R7", "busy low at done", {62'd0, busy, done}, 1);
      end

      // R8: done and signature hold
      held = signature;
      repeat (20) @(negedge clk);
      check(done && signature == held, "R8", "done/signature hold", signature, held);

      // R2: start while busy is ignored
      run_bist(500, cyc);
      check(cyc == EXP_CYC, "R2", "run length with stray start", W'(cyc), W'(EXP_CYC));
      check(signature == gold, "R2", "signature with stray start", signature, gold);

      // R6: relaunch reseeds the MISR
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy && !done && signature == SEED, "R6", "reseed at launch", signature, SEED);
      do @(negedge clk); while (!done);
      check(signature == gold, "R6", "signature after relaunch", signature, gold);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule